// File: doc/BRIEF.md
# Two-Port Memory Array Arbiter with Refresh

This block decides who may use a shared DRAM array: port A, port B or an internal refresh sequencer. All three work off one system clock. A single select output, `grant_b`, tells the surrounding datapath which port's row, column, bank, lock and byte-strobe signals to steer onto the array. When a port asks for the array and is not being served, its stall output stays high. The port then holds its access open until the stall drops.

The port that holds the select can raise its lock input. While the lock is up, the select cannot move to the other port, even across idle periods. The other port is stalled until the lock falls. Refresh requests are built by counting pulses of a slow tick derived from a divided clock. A refresh beats a new port grant, but it never cuts into an access already running. A held lock may put off a pending refresh only for a bounded number of cycles. Every access and every refresh is followed by a precharge gap counted in system clocks.

Top module: `dram_port_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `grant_b`, `row_active` and `refresh_busy` are 0.
- R2: `grant_b`=0 means port A owns the array and `grant_b`=1 means port B owns it. The select changes only at the end of an idle arbitration cycle. It never changes during an access, a precharge or a refresh.
- R3: A lone request into an idle array is served in the next cycle. In that cycle its stall output is low, `row_active` is high and `grant_b` names the port.
- R4: When both ports request in the same idle cycle and no lock is in force, the port that did not win the previous unlocked grant is served. The first such tie after reset goes to port A.
- R5: A port's stall output is high in every cycle in which its request is high and it is not the port being served.
- R6: While the owning port holds its lock, the select stays on that port and a request from the other port keeps that port's stall output high.
- R7: If the lock falls while the array is idle and the other port is requesting, that port is served in the next cycle.
- R8: When the owner drops its request, `row_active` stays low for PRE_CYC precharge cycles plus one idle arbitration cycle before any new access starts.
- R9: Every REFRESH_DIV-th pulse of `refresh_tick` makes a refresh pending. A refresh holds `refresh_busy` and `row_active` high for RAS_CYC cycles, followed by PRE_CYC precharge cycles.
- R10: In an idle cycle, a pending refresh is taken ahead of any port request.
- R11: A pending refresh waits while an access is in progress. It starts after that access's precharge and one idle cycle.
- R12: A held lock delays a pending refresh by at most MAX_DEFER cycles. The refresh then runs despite the lock. The select and the lock hold are unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | 1 | Port A access request, held for the length of the access |
| req_b | input | 1 | Port B access request, held for the length of the access |
| lock_a | input | 1 | Port A lock, effective while port A holds the select |
| lock_b | input | 1 | Port B lock, effective while port B holds the select |
| refresh_tick | input | 1 | One-cycle pulse from the divided refresh clock |
| grant_b | output | 1 | Array select: 1 = port B, 0 = port A |
| wait_a | output | 1 | Stall for port A |
| wait_b | output | 1 | Stall for port B |
| row_active | output | 1 | Row strobe active, for an access or a refresh |
| refresh_busy | output | 1 | Refresh cycle in progress |

## Verification
A sequencer stuck in the wrong phase shows up within one cycle as a stall output that is high for the served port, or low for a port that is blocked. It also shows up as a `row_active` gap whose length differs from PRE_CYC plus one. A wrong round-robin or lock memory appears at the next tie or lock release as `grant_b` naming the wrong port. A wrong refresh tick count or deferral limit moves the rising edge of `refresh_busy` by whole cycles. The bench therefore checks that edge in the exact cycle where it is due.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

    localparam int NPORT  = 2;
    localparam int PORT_A = 0;
    localparam int PORT_B = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_PRECH,
        ST_REFRESH
    } arb_state_e;

    typedef struct packed {
        logic req;
        logic lock;
    } port_in_t;

    // Port chosen for an unlocked grant: on a tie, the one that did not win last.
    function automatic logic choose_port(input logic ra, input logic rb, input logic last_b);
        if (ra && rb) begin
            return !last_b;
        end
        return rb;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/dparb_refresh_req.sv
module dparb_refresh_req
    import dparb_pkg::*;
#(
    parameter int unsigned REFRESH_DIV = 4,
    parameter int unsigned MAX_DEFER   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic take_i,
    input  logic hold_i,
    output logic pend_o,
    output logic defer_done_o
);
    localparam int unsigned TW = cnt_width(REFRESH_DIV - 1);
    localparam int unsigned XW = cnt_width(MAX_DEFER);

    logic [TW-1:0] tick_cnt_q;
    logic [XW-1:0] defer_q;
    logic          pend_q;
    logic          wrap;

    assign wrap = tick_i && (tick_cnt_q == TW'(REFRESH_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt_q <= '0;
        end else if (tick_i) begin
            tick_cnt_q <= wrap ? '0 : tick_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= wrap || (pend_q && !take_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || take_i || !pend_q) begin
            defer_q <= '0;
        end else if (hold_i && (defer_q != XW'(MAX_DEFER))) begin
            defer_q <= defer_q + 1'b1;
        end
    end

    assign pend_o       = pend_q;
    assign defer_done_o = (defer_q == XW'(MAX_DEFER));

    AST_PEND_CLEARS_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        (take_i && !wrap) |=> !pend_o);   // R9
    AST_DEFER_ONLY_WHILE_PEND: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> !defer_done_o || (MAX_DEFER == 0));   // R12

endmodule

// File: rtl/dparb_sequencer.sv
module dparb_sequencer
    import dparb_pkg::*;
#(
    parameter int unsigned PRE_CYC = 2,
    parameter int unsigned RAS_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  port_in_t [NPORT-1:0] port_i,
    input  logic             rfsh_pend_i,
    input  logic             defer_done_i,
    output logic             take_o,
    output logic             lock_eff_o,
    output logic             grant_b_o,
    output logic [NPORT-1:0] serve_o,
    output logic             row_active_o,
    output logic             rfsh_busy_o
);
    localparam int unsigned MAXC = (PRE_CYC > RAS_CYC) ? PRE_CYC : RAS_CYC;
    localparam int unsigned CW   = cnt_width(MAXC);

    arb_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          grant_q, grant_d;
    logic          last_q, last_d;
    logic          owner_req, lock_eff, any_req, pick;

    assign owner_req = port_i[grant_q].req;
    assign lock_eff  = port_i[grant_q].lock;
    assign any_req   = port_i[PORT_A].req || port_i[PORT_B].req;
    assign pick      = choose_port(port_i[PORT_A].req, port_i[PORT_B].req, last_q);

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        grant_d = grant_q;
        last_d  = last_q;
        take_o  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (rfsh_pend_i && (!lock_eff || defer_done_i)) begin
                    take_o = 1'b1;
                    st_d   = ST_REFRESH;
                    cnt_d  = CW'(RAS_CYC - 1);
                end else if (lock_eff) begin
                    if (owner_req) begin
                        st_d = ST_ACCESS;
                    end
                end else if (any_req) begin
                    grant_d = pick;
                    last_d  = pick;
                    st_d    = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (!owner_req) begin
                    st_d  = ST_PRECH;
                    cnt_d = CW'(PRE_CYC - 1);
                end
            end
            ST_PRECH: begin
                if (cnt_q == '0) begin
                    st_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_REFRESH: begin
                if (cnt_q == '0) begin
                    st_d  = ST_PRECH;
                    cnt_d = CW'(PRE_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            grant_q <= 1'b0;
            last_q  <= 1'b1;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            grant_q <= grant_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        serve_o = '0;
        if (st_q == ST_ACCESS) begin
            serve_o[grant_q] = 1'b1;
        end
    end

    assign lock_eff_o   = lock_eff;
    assign grant_b_o    = grant_q;
    assign row_active_o = (st_q == ST_ACCESS) || (st_q == ST_REFRESH);
    assign rfsh_busy_o  = (st_q == ST_REFRESH);

    AST_GRANT_MOVES_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(grant_q) |-> $past(st_q == ST_IDLE));   // R2
    AST_ACCESS_ENDS_IN_PRECH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACCESS) |=> (st_q == ST_ACCESS) || (st_q == ST_PRECH));   // R8
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACCESS && owner_req) |=> (st_q == ST_ACCESS));   // R11
    AST_REFRESH_TO_PRECH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REFRESH && cnt_q == '0) |=> (st_q == ST_PRECH));   // R9
    AST_LOCK_HOLDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && lock_eff) |=> $stable(grant_q));   // R6
    AST_DEFER_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && rfsh_pend_i && defer_done_i) |=> (st_q == ST_REFRESH));   // R12

endmodule

// File: rtl/dparb_wait_gen.sv
module dparb_wait_gen
    import dparb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req_i,
    input  logic [NPORT-1:0] serve_i,
    input  logic             row_active_i,
    output logic [NPORT-1:0] wait_o
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign wait_o[p] = req_i[p] && !serve_i[p];

        AST_STALL_WHEN_UNSERVED: assert property (@(posedge clk) disable iff (rst)
            (req_i[p] && !row_active_i) |-> wait_o[p]);   // R5
    end

    AST_ONE_SERVED: assert property (@(posedge clk) disable iff (rst)
        $onehot0(serve_i));   // R2

endmodule

// File: rtl/dram_port_arbiter.sv
module dram_port_arbiter
    import dparb_pkg::*;
#(
    parameter int unsigned PRE_CYC     = 2,
    parameter int unsigned RAS_CYC     = 3,
    parameter int unsigned REFRESH_DIV = 4,
    parameter int unsigned MAX_DEFER   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic req_a,
    input  logic req_b,
    input  logic lock_a,
    input  logic lock_b,
    input  logic refresh_tick,
    output logic grant_b,
    output logic wait_a,
    output logic wait_b,
    output logic row_active,
    output logic refresh_busy
);
    port_in_t [NPORT-1:0] ports;
    logic [NPORT-1:0]     reqs, serve, waits;
    logic                 pend, defer_done, take, lock_eff;

    assign ports[PORT_A] = '{req: req_a, lock: lock_a};
    assign ports[PORT_B] = '{req: req_b, lock: lock_b};
    assign reqs          = {req_b, req_a};

    dparb_refresh_req #(
        .REFRESH_DIV (REFRESH_DIV),
        .MAX_DEFER   (MAX_DEFER)
    ) rfsh_i (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (refresh_tick),
        .take_i       (take),
        .hold_i       (lock_eff),
        .pend_o       (pend),
        .defer_done_o (defer_done)
    );

    dparb_sequencer #(
        .PRE_CYC (PRE_CYC),
        .RAS_CYC (RAS_CYC)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .port_i       (ports),
        .rfsh_pend_i  (pend),
        .defer_done_i (defer_done),
        .take_o       (take),
        .lock_eff_o   (lock_eff),
        .grant_b_o    (grant_b),
        .serve_o      (serve),
        .row_active_o (row_active),
        .rfsh_busy_o  (refresh_busy)
    );

    dparb_wait_gen wait_i (
        .clk          (clk),
        .rst          (rst),
        .req_i        (reqs),
        .serve_i      (serve),
        .row_active_i (row_active),
        .wait_o       (waits)
    );

    assign wait_a = waits[PORT_A];
    assign wait_b = waits[PORT_B];

endmodule

// File: tb/dram_port_arbiter_tb_top.sv
module dram_port_arbiter_tb_top;
    localparam int PRE  = 2;
    localparam int RAS  = 3;
    localparam int DIV  = 4;
    localparam int MAXD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_a = 1'b0, req_b = 1'b0, lock_a = 1'b0, lock_b = 1'b0, refresh_tick = 1'b0;
    logic grant_b, wait_a, wait_b, row_active, refresh_busy;
    int   n_chk = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;

    dram_port_arbiter #(
        .PRE_CYC (PRE), .RAS_CYC (RAS), .REFRESH_DIV (DIV), .MAX_DEFER (MAXD)
    ) dut_i (
        .clk (clk), .rst (rst), .req_a (req_a), .req_b (req_b),
        .lock_a (lock_a), .lock_b (lock_b), .refresh_tick (refresh_tick),
        .grant_b (grant_b), .wait_a (wait_a), .wait_b (wait_b),
        .row_active (row_active), .refresh_busy (refresh_busy)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (PRE + 1) nxt();
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            nxt(); refresh_tick = 1'b1;
            nxt(); refresh_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        repeat (3) nxt();
        #1;
        chk("R1", "grant_b in reset", grant_b, 1'b0);
        chk("R1", "row_active in reset", row_active, 1'b0);
        chk("R1", "refresh_busy in reset", refresh_busy, 1'b0);
        rst = 1'b0;
        nxt(); #1;
        chk("R1", "grant_b after reset", grant_b, 1'b0);
        chk("R1", "row_active after reset", row_active, 1'b0);
    endtask

    task automatic t_single_and_precharge();
        nxt(); req_a = 1'b1; #1;
        chk("R5", "wait_a before service", wait_a, 1'b1);
        chk("R3", "row idle on request cycle", row_active, 1'b0);
        nxt(); #1;
        chk("R3", "wait_a served", wait_a, 1'b0);
        chk("R3", "row active", row_active, 1'b1);
        chk("R3", "grant to A", grant_b, 1'b0);
        nxt(); req_a = 1'b0; req_b = 1'b1; #1;
        chk("R5", "wait_b while A finishes", wait_b, 1'b1);
        for (int k = 0; k < PRE + 1; k++) begin
            nxt(); #1;
            chk("R8", "row low in precharge/idle", row_active, 1'b0);
            chk("R8", "wait_b during gap", wait_b, 1'b1);
            chk("R2", "grant held in gap", grant_b, 1'b0);
        end
        nxt(); #1;
        chk("R8", "wait_b released after gap", wait_b, 1'b0);
        chk("R2", "grant moved to B", grant_b, 1'b1);
        chk("R8", "row active for B", row_active, 1'b1);
        nxt(); req_b = 1'b0;
        settle();
    endtask

    task automatic t_tie();
        nxt(); req_a = 1'b1; req_b = 1'b1;
        nxt(); #1;
        chk("R4", "first tie to A", grant_b, 1'b0);
        chk("R4", "loser B stalls", wait_b, 1'b1);
        nxt(); req_a = 1'b0; req_b = 1'b0;
        settle();
        nxt(); req_a = 1'b1; req_b = 1'b1;
        nxt(); #1;
        chk("R4", "second tie to B", grant_b, 1'b1);
        chk("R4", "loser A stalls", wait_a, 1'b1);
        nxt(); req_a = 1'b0; req_b = 1'b0;
        settle();
    endtask

    task automatic t_lock();
        nxt(); req_a = 1'b1; lock_a = 1'b1;
        nxt(); req_b = 1'b1; #1;
        chk("R6", "A granted with lock", grant_b, 1'b0);
        chk("R6", "B stalls behind A", wait_b, 1'b1);
        nxt(); req_a = 1'b0;
        for (int k = 0; k < PRE + 4; k++) begin
            nxt(); #1;
            chk("R6", "B still stalled under lock", wait_b, 1'b1);
            chk("R6", "grant stays A under lock", grant_b, 1'b0);
        end
        nxt(); lock_a = 1'b0; #1;
        chk("R7", "B stalled in lock-drop cycle", wait_b, 1'b1);
        nxt(); #1;
        chk("R7", "B served one cycle after lock drop", wait_b, 1'b0);
        chk("R7", "grant moved to B", grant_b, 1'b1);
        nxt(); req_b = 1'b0;
        settle();
    endtask

    task automatic t_refresh_priority();
        pulse_ticks(DIV - 1);
        nxt(); #1;
        chk("R9", "no refresh before count", refresh_busy, 1'b0);
        nxt(); #1;
        chk("R9", "still no refresh", refresh_busy, 1'b0);
        pulse_ticks(1);
        req_a = 1'b1; #1;
        chk("R10", "refresh not yet started", refresh_busy, 1'b0);
        chk("R10", "A stalls", wait_a, 1'b1);
        for (int k = 0; k < RAS; k++) begin
            nxt(); #1;
            chk("R9", "refresh busy", refresh_busy, 1'b1);
            chk("R9", "row active in refresh", row_active, 1'b1);
            chk("R10", "A stalled by refresh", wait_a, 1'b1);
        end
        for (int k = 0; k < PRE; k++) begin
            nxt(); #1;
            chk("R9", "refresh precharge", row_active, 1'b0);
        end
        nxt(); #1;
        chk("R10", "A stalled in idle cycle", wait_a, 1'b1);
        nxt(); #1;
        chk("R10", "A served after refresh", wait_a, 1'b0);
        chk("R10", "grant A", grant_b, 1'b0);
    endtask

    task automatic t_no_preempt();
        pulse_ticks(DIV);
        for (int k = 0; k < 3; k++) begin
            nxt(); #1;
            chk("R11", "no refresh during access", refresh_busy, 1'b0);
            chk("R11", "A keeps access", wait_a, 1'b0);
        end
        nxt(); req_a = 1'b0;
        for (int k = 0; k < PRE + 1; k++) begin
            nxt(); #1;
            chk("R11", "refresh waits for precharge", refresh_busy, 1'b0);
        end
        nxt(); #1;
        chk("R11", "refresh after access", refresh_busy, 1'b1);
        repeat (RAS - 1 + PRE + 1) nxt();
    endtask

    task automatic t_lock_defer();
        nxt(); lock_a = 1'b1; req_b = 1'b1;
        pulse_ticks(DIV);
        #1;
        chk("R12", "refresh deferred at pend", refresh_busy, 1'b0);
        for (int k = 1; k <= MAXD; k++) begin
            nxt(); #1;
            chk("R12", "refresh deferred by lock", refresh_busy, 1'b0);
            chk("R6", "B stalled under lock", wait_b, 1'b1);
        end
        nxt(); #1;
        chk("R12", "refresh forced at limit", refresh_busy, 1'b1);
        repeat (RAS - 1 + PRE + 1) nxt();
        #1;
        chk("R12", "lock still holds after refresh", wait_b, 1'b1);
        chk("R12", "grant unchanged by refresh", grant_b, 1'b0);
        lock_a = 1'b0;
        nxt(); #1;
        chk("R7", "B served after lock drop", wait_b, 1'b0);
        chk("R7", "grant to B", grant_b, 1'b1);
        nxt(); req_b = 1'b0;
        settle();
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single_and_precharge();
        t_tie();
        t_lock();
        t_refresh_priority();
        t_no_preempt();
        t_lock_defer();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule